// File: doc/BRIEF.md
# Power domain on/off sequencer

This block brings a gated logic domain and its embedded memories up and down in a fixed order, with fixed waits between the steps. A power-on request starts the power-up walk and a power-off request starts the power-down walk. Every wait is counted in one-microsecond ticks from an external prescaler. The block drives the domain power switch, the isolation enable, 72 memory power-down controls, a reset bundle and two clock enables. It reports whether the domain is powered and whether a sequence is in progress.

The memories form two groups. The first group is 32 banks, each with a two-bit control field. The second group is 8 single power-down bits. Only the upper bit of each bank field is ever changed. The memory sweep handles one control at a time and waits after each one. The two walks put the switch, isolation, resets and clocks in different orders. When power is removed, isolation is raised before anything else and the clocks are dropped last. When power is restored, the switch comes first and the clocks come last, after the isolation has been released under reset.

Top module: `pwr_dom_seq`

## Requirements
- R1: During and after reset the outputs follow `boot_on_i`. With `boot_on_i`=1: switch on, isolation off, every memory control 0, clocks `2'b11`, powered 1. With `boot_on_i`=0: switch off, isolation on, bank upper bits (bit 2k+1 for bank k) at 1, auxiliary bits at 1, clocks `2'b00`, powered 0. In both cases resets are 0 and busy is 0.
- R2: A power-off walk raises isolation one cycle after the request is accepted. With a tick in every cycle, the first memory step follows 21 cycles later (20 ticks).
- R3: Both walks use the same memory order. Bank k (0..31) comes first, by its upper bit at position 2k+1 of `bank_pd_o`, then auxiliary bit j (0..7). There is exactly one change per step, and steps are 6 cycles apart (5 ticks). Power-off sets each control to 1 and power-on clears it to 0. Bank lower bits (even positions) stay 0.
- R4: During power-off, the switch drops 27 cycles after the last memory step (5 ticks + 20 ticks). Clocks clear to `2'b00` and powered drops together, 20001 cycles later (20000 ticks).
- R5: During power-on, the switch rises one cycle after the request is accepted. The first memory clear follows 21 cycles later.
- R6: During power-on, all reset lines rise together 27 cycles after the last memory clear. Isolation falls in the next cycle and the resets fall in the cycle after that.
- R7: During power-on, `clk_en_o[0]` rises one cycle after the reset release and `clk_en_o[1]` rises one cycle later. Powered rises one cycle after that.
- R8: A power-on request while powered, or a power-off request while unpowered, changes no output, and busy stays 0.
- R9: A request that arrives while a walk is running is ignored. The walk keeps its order and timing.
- R10: Waits advance only on cycles with `tick_us_i`=1. Without ticks, the outputs hold.
- R11: Busy rises in the cycle after a request is accepted. It falls in the same cycle as the final step (powered rising or dropping).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_on_i | input | 1 | State of the power switch while in reset; selects the reset values |
| tick_us_i | input | 1 | One-microsecond tick |
| on_req_i | input | 1 | Power-on request |
| off_req_i | input | 1 | Power-off (shutdown) request |
| pwr_sw_o | output | 1 | Domain power switch enable |
| iso_o | output | 1 | Isolation enable |
| bank_pd_o | output | 64 | Bank power-down fields, two bits per bank |
| aux_pd_o | output | 8 | Auxiliary memory power-down bits |
| dom_rst_o | output | 12 | Domain reset bundle, active high |
| clk_en_o | output | 2 | Clock enables |
| powered_o | output | 1 | Domain powered status |
| busy_o | output | 1 | A sequence is in progress |

## Verification
If the wait counter loads a wrong count or misses a tick, the spacing between two consecutive output changes is wrong, and this shows at the very next step. A step index that skips or repeats moves the next memory bit that toggles to another position, or toggles two bits at once, within six cycles. A state register that takes a wrong branch changes the order of the isolation, switch, reset and clock edges, or lets a redundant request raise busy. Each of these differs at the ports within one cycle of the faulty transition.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OFF_ISO,
    ST_OFF_MEM,
    ST_OFF_TAIL,
    ST_OFF_SW,
    ST_OFF_CLK,
    ST_ON_SW,
    ST_ON_MEM,
    ST_ON_TAIL,
    ST_ON_RST,
    ST_ON_ISO,
    ST_ON_RLS,
    ST_ON_CLK0,
    ST_ON_CLK1,
    ST_ON_DONE
  } pds_state_e;
endpackage

// File: rtl/pds_timer.sv
module pds_timer #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  assert_hold_no_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(cnt_q));

  assert_zero_sticks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && zero_o) |=> zero_o);
endmodule

// File: rtl/pds_mem_ctrl.sv
module pds_mem_ctrl #(
  parameter int N_BANK = 32,
  parameter int N_AUX  = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  boot_on_i,
  input  logic                  start_i,
  input  logic                  step_i,
  input  logic                  pd_val_i,
  output logic [2*N_BANK-1:0]   bank_pd_o,
  output logic [N_AUX-1:0]      aux_pd_o,
  output logic                  last_o
);
  localparam int N_STEP = N_BANK + N_AUX;
  localparam int IDX_W  = $clog2(N_STEP);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (start_i) idx_q <= '0;
    else if (step_i)  idx_q <= idx_q + 1'b1;
  end

  assign last_o = (idx_q == IDX_W'(N_STEP - 1));

  for (genvar g = 0; g < N_BANK; g++) begin : g_bank
    logic hi_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              hi_q <= !boot_on_i;
      else if (step_i && idx_q == IDX_W'(g))    hi_q <= pd_val_i;
    end
    assign bank_pd_o[2*g]   = 1'b0;
    assign bank_pd_o[2*g+1] = hi_q;
  end

  for (genvar g = 0; g < N_AUX; g++) begin : g_aux
    logic pd_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     pd_q <= !boot_on_i;
      else if (step_i && idx_q == IDX_W'(N_BANK + g))  pd_q <= pd_val_i;
    end
    assign aux_pd_o[g] = pd_q;
  end

  assert_one_change_per_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> ($countones({bank_pd_o, aux_pd_o} ^ $past({bank_pd_o, aux_pd_o})) == 1));

  assert_no_change_between_steps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> ($stable(bank_pd_o) && $stable(aux_pd_o)));
endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
  import pds_pkg::*;
#(
  parameter int CNT_W          = 15,
  parameter int WAIT_EDGE_US   = 20,
  parameter int WAIT_MEM_US    = 5,
  parameter int WAIT_SETTLE_US = 20000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             boot_on_i,
  input  logic             on_req_i,
  input  logic             off_req_i,
  input  logic             t_zero_i,
  input  logic             m_last_i,
  output logic             t_load_o,
  output logic [CNT_W-1:0] t_val_o,
  output logic             m_start_o,
  output logic             m_step_o,
  output logic             m_pd_val_o,
  output logic             sw_o,
  output logic             iso_o,
  output logic             rst_o,
  output logic [1:0]       clk_en_o,
  output logic             powered_o,
  output logic             busy_o
);
  pds_state_e state_q, state_d;
  logic       sw_q, sw_d, iso_q, iso_d, rst_q, rst_d, pow_q, pow_d;
  logic [1:0] clk_q, clk_d;

  always_comb begin
    state_d    = state_q;
    sw_d       = sw_q;
    iso_d      = iso_q;
    rst_d      = rst_q;
    clk_d      = clk_q;
    pow_d      = pow_q;
    t_load_o   = 1'b0;
    t_val_o    = '0;
    m_start_o  = 1'b0;
    m_step_o   = 1'b0;
    m_pd_val_o = (state_q == ST_OFF_MEM);
    if (state_q == ST_IDLE) begin
      if (on_req_i && !pow_q) begin
        state_d   = ST_ON_SW;
        m_start_o = 1'b1;
      end else if (off_req_i && pow_q) begin
        state_d   = ST_OFF_ISO;
        m_start_o = 1'b1;
      end
    end else if (t_zero_i) begin
      unique case (state_q)
        ST_OFF_ISO: begin
          iso_d = 1'b1; t_load_o = 1'b1; t_val_o = CNT_W'(WAIT_EDGE_US);
          state_d = ST_OFF_MEM;
        end
        ST_OFF_MEM, ST_ON_MEM: begin
          m_step_o = 1'b1; t_load_o = 1'b1; t_val_o = CNT_W'(WAIT_MEM_US);
          if (m_last_i) state_d = (state_q == ST_OFF_MEM) ? ST_OFF_TAIL : ST_ON_TAIL;
        end
        ST_OFF_TAIL: begin
          t_load_o = 1'b1; t_val_o = CNT_W'(WAIT_EDGE_US);
          state_d = ST_OFF_SW;
        end
        ST_OFF_SW: begin
          sw_d = 1'b0; t_load_o = 1'b1; t_val_o = CNT_W'(WAIT_SETTLE_US);
          state_d = ST_OFF_CLK;
        end
        ST_OFF_CLK: begin
          clk_d = 2'b00; pow_d = 1'b0; state_d = ST_IDLE;
        end
        ST_ON_SW: begin
          sw_d = 1'b1; t_load_o = 1'b1; t_val_o = CNT_W'(WAIT_EDGE_US);
          state_d = ST_ON_MEM;
        end
        ST_ON_TAIL: begin
          t_load_o = 1'b1; t_val_o = CNT_W'(WAIT_EDGE_US);
          state_d = ST_ON_RST;
        end
        ST_ON_RST:  begin rst_d = 1'b1;    state_d = ST_ON_ISO;  end
        ST_ON_ISO:  begin iso_d = 1'b0;    state_d = ST_ON_RLS;  end
        ST_ON_RLS:  begin rst_d = 1'b0;    state_d = ST_ON_CLK0; end
        ST_ON_CLK0: begin clk_d[0] = 1'b1; state_d = ST_ON_CLK1; end
        ST_ON_CLK1: begin clk_d[1] = 1'b1; state_d = ST_ON_DONE; end
        ST_ON_DONE: begin pow_d = 1'b1;    state_d = ST_IDLE;    end
        default:    state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sw_q    <= boot_on_i;
      iso_q   <= !boot_on_i;
      rst_q   <= 1'b0;
      clk_q   <= {2{boot_on_i}};
      pow_q   <= boot_on_i;
    end else begin
      state_q <= state_d;
      sw_q    <= sw_d;
      iso_q   <= iso_d;
      rst_q   <= rst_d;
      clk_q   <= clk_d;
      pow_q   <= pow_d;
    end
  end

  assign sw_o      = sw_q;
  assign iso_o     = iso_q;
  assign rst_o     = rst_q;
  assign clk_en_o  = clk_q;
  assign powered_o = pow_q;
  assign busy_o    = (state_q != ST_IDLE);

  assert_iso_before_switch_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_q) |-> iso_q);
  assert_drop_clocks_unpowered_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pow_q) |-> (clk_q == 2'b00 && !sw_q && iso_q));
  assert_iso_release_in_reset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(iso_q) |-> (rst_q && sw_q));
  assert_reset_release_no_iso_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_q) |-> !iso_q);
  assert_clock_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_q[1]) |-> clk_q[0]);
  assert_powered_after_clocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pow_q) |-> (clk_q == 2'b11 && !rst_q));
  assert_status_moves_in_walk_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pow_q) |-> $past(state_q != ST_IDLE));
  assert_switch_moves_in_walk_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sw_q) |-> $past(state_q != ST_IDLE));
endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq #(
  parameter int N_BANK         = 32,
  parameter int N_AUX          = 8,
  parameter int N_RST          = 12,
  parameter int WAIT_EDGE_US   = 20,
  parameter int WAIT_MEM_US    = 5,
  parameter int WAIT_SETTLE_US = 20000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                boot_on_i,
  input  logic                tick_us_i,
  input  logic                on_req_i,
  input  logic                off_req_i,
  output logic                pwr_sw_o,
  output logic                iso_o,
  output logic [2*N_BANK-1:0] bank_pd_o,
  output logic [N_AUX-1:0]    aux_pd_o,
  output logic [N_RST-1:0]    dom_rst_o,
  output logic [1:0]          clk_en_o,
  output logic                powered_o,
  output logic                busy_o
);
  localparam int MAX_WAIT = (WAIT_SETTLE_US > WAIT_EDGE_US) ? WAIT_SETTLE_US : WAIT_EDGE_US;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  logic             t_load, t_zero, m_start, m_step, m_pd_val, m_last, rst_grp;
  logic [CNT_W-1:0] t_val;

  pds_fsm #(
    .CNT_W(CNT_W), .WAIT_EDGE_US(WAIT_EDGE_US),
    .WAIT_MEM_US(WAIT_MEM_US), .WAIT_SETTLE_US(WAIT_SETTLE_US)
  ) i_fsm (
    .clk_i, .rst_ni, .boot_on_i, .on_req_i, .off_req_i,
    .t_zero_i(t_zero), .m_last_i(m_last),
    .t_load_o(t_load), .t_val_o(t_val),
    .m_start_o(m_start), .m_step_o(m_step), .m_pd_val_o(m_pd_val),
    .sw_o(pwr_sw_o), .iso_o(iso_o), .rst_o(rst_grp), .clk_en_o(clk_en_o),
    .powered_o(powered_o), .busy_o(busy_o)
  );

  pds_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i, .rst_ni, .tick_i(tick_us_i), .load_i(t_load),
    .load_val_i(t_val), .zero_o(t_zero)
  );

  pds_mem_ctrl #(.N_BANK(N_BANK), .N_AUX(N_AUX)) i_mem (
    .clk_i, .rst_ni, .boot_on_i, .start_i(m_start), .step_i(m_step),
    .pd_val_i(m_pd_val), .bank_pd_o(bank_pd_o), .aux_pd_o(aux_pd_o), .last_o(m_last)
  );

  assign dom_rst_o = {N_RST{rst_grp}};
endmodule

// File: tb/test_pwr_dom_seq.sv
module test_pwr_dom_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 90;

  localparam logic [3:0] K_REQ_ON = 4'd0, K_REQ_OFF = 4'd1, K_BUSY = 4'd2, K_SW_ON = 4'd3,
    K_SW_OFF = 4'd4, K_ISO_ON = 4'd5, K_ISO_OFF = 4'd6, K_MEM_SET = 4'd7, K_MEM_CLR = 4'd8,
    K_RST_ON = 4'd9, K_RST_OFF = 4'd10, K_CLK0 = 4'd11, K_CLK1 = 4'd12, K_ON_DONE = 4'd13,
    K_OFF_DONE = 4'd14;

  localparam int N_ROWS = 16;
  localparam logic [19:0] seq_tab [N_ROWS] = '{
    {K_REQ_ON, 16'd0}, {K_BUSY, 16'd1}, {K_SW_ON, 16'd1}, {K_MEM_CLR, 16'd21},
    {K_RST_ON, 16'd27}, {K_ISO_OFF, 16'd1}, {K_RST_OFF, 16'd1}, {K_CLK0, 16'd1},
    {K_CLK1, 16'd1}, {K_ON_DONE, 16'd1},
    {K_REQ_OFF, 16'd0}, {K_BUSY, 16'd1}, {K_ISO_ON, 16'd1}, {K_MEM_SET, 16'd21},
    {K_SW_OFF, 16'd27}, {K_OFF_DONE, 16'd20001}
  };

  logic clk = 1'b0, rst_n = 1'b0, boot_on = 1'b0, tick = 1'b1, on_req = 1'b0, off_req = 1'b0;
  logic pwr_sw, iso, powered, busy;
  logic [63:0] bank_pd;
  logic [7:0]  aux_pd;
  logic [11:0] dom_rst;
  logic [1:0]  clk_en;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit inj_pending = 1'b0, inj_on = 1'b0;

  logic m_sw, m_iso, m_pow, m_busy;
  logic [63:0] m_bank;
  logic [7:0]  m_aux;
  logic [11:0] m_rst;
  logic [1:0]  m_clk;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_dom_seq i_pwr_dom_seq (
    .clk_i(clk), .rst_ni(rst_n), .boot_on_i(boot_on), .tick_us_i(tick),
    .on_req_i(on_req), .off_req_i(off_req), .pwr_sw_o(pwr_sw), .iso_o(iso),
    .bank_pd_o(bank_pd), .aux_pd_o(aux_pd), .dom_rst_o(dom_rst), .clk_en_o(clk_en),
    .powered_o(powered), .busy_o(busy)
  );

  function automatic logic [SW-1:0] act_snap();
    return {pwr_sw, iso, bank_pd, aux_pd, dom_rst, clk_en, powered, busy};
  endfunction

  function automatic logic [SW-1:0] exp_snap();
    return {m_sw, m_iso, m_bank, m_aux, m_rst, m_clk, m_pow, m_busy};
  endfunction

  task automatic model_reset(input logic on);
    m_sw = on; m_iso = !on; m_rst = '0; m_clk = {2{on}}; m_pow = on; m_busy = 1'b0;
    m_aux = {8{!on}};
    m_bank = '0;
    for (int k = 0; k < 32; k++) m_bank[2*k+1] = !on;
  endtask

  task automatic chk_snap(input string tag);
    checks++;
    if (act_snap() !== exp_snap()) begin
      errors++;
      $display("FAIL %s: outputs act=%h exp=%h", tag, act_snap(), exp_snap());
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // counts cycles until any output changes; clears requests after one edge
  task automatic wait_change(output int gap);
    logic [SW-1:0] prev;
    prev = act_snap();
    gap = 0;
    forever begin
      @(posedge clk);
      @(negedge clk);
      gap++;
      on_req = 1'b0;
      off_req = 1'b0;
      if (inj_pending && gap == 1) begin
        if (inj_on) on_req = 1'b1; else off_req = 1'b1;
        inj_pending = 1'b0;
      end
      if (act_snap() !== prev) break;
      if (gap > 25000) begin
        errors++;
        $display("FAIL timeout: no output change act=%0d exp=<25000", gap);
        break;
      end
    end
  endtask

  task automatic do_reset(input logic on);
    rst_n = 1'b0; boot_on = on;
    repeat (3) @(negedge clk);
    model_reset(on);
    chk_snap("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_snap("R1 after reset");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act=expired exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int gap;
    @(negedge clk);
    do_reset(1'b0);

    // R8: power-off request while already off
    off_req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      off_req = 1'b0;
      chk_snap("R8 redundant off");
    end

    // table walk: full on sequence then full off sequence
    for (int r = 0; r < N_ROWS; r++) begin
      logic [3:0] kind;
      int exp_gap;
      kind = seq_tab[r][19:16];
      exp_gap = int'(seq_tab[r][15:0]);
      if (kind == K_REQ_ON) begin on_req = 1'b1; continue; end
      if (kind == K_REQ_OFF) begin off_req = 1'b1; continue; end
      if (kind == K_MEM_SET || kind == K_MEM_CLR) begin
        for (int s = 0; s < 40; s++) begin
          if (s == 10) begin inj_pending = 1'b1; inj_on = (kind == K_MEM_SET); end
          wait_change(gap);
          if (s < 32) m_bank[2*s+1] = (kind == K_MEM_SET);
          else        m_aux[s-32]   = (kind == K_MEM_SET);
          chk_int((s == 10) ? "R9 step gap after stray request" :
                  (s == 0 && kind == K_MEM_SET) ? "R2 iso to first memory" :
                  (s == 0) ? "R5 switch to first memory" : "R3 step gap",
                  gap, (s == 0) ? exp_gap : 6);
          chk_snap((s == 10) ? "R9 step value" : "R3 step value");
        end
        continue;
      end
      wait_change(gap);
      case (kind)
        K_BUSY:     m_busy = 1'b1;
        K_SW_ON:    m_sw = 1'b1;
        K_SW_OFF:   m_sw = 1'b0;
        K_ISO_ON:   m_iso = 1'b1;
        K_ISO_OFF:  m_iso = 1'b0;
        K_RST_ON:   m_rst = '1;
        K_RST_OFF:  m_rst = '0;
        K_CLK0:     m_clk[0] = 1'b1;
        K_CLK1:     m_clk[1] = 1'b1;
        K_ON_DONE:  begin m_pow = 1'b1; m_busy = 1'b0; end
        K_OFF_DONE: begin m_clk = 2'b00; m_pow = 1'b0; m_busy = 1'b0; end
        default: ;
      endcase
      case (kind)
        K_BUSY:                         chk_int("R11 busy gap", gap, exp_gap);
        K_SW_ON:                        chk_int("R5 switch gap", gap, exp_gap);
        K_ISO_ON:                       chk_int("R2 iso gap", gap, exp_gap);
        K_SW_OFF, K_OFF_DONE:           chk_int("R4 tail gap", gap, exp_gap);
        K_RST_ON, K_ISO_OFF, K_RST_OFF: chk_int("R6 order gap", gap, exp_gap);
        default:                        chk_int("R7 clock gap", gap, exp_gap);
      endcase
      chk_snap((kind == K_OFF_DONE) ? "R4 value" :
               (kind == K_ON_DONE) ? "R11 value" : "R6 R7 value");
    end

    // R10: no ticks, no progress
    tick = 1'b0;
    on_req = 1'b1;
    @(negedge clk); on_req = 1'b0;
    @(negedge clk);
    m_busy = 1'b1; m_sw = 1'b1;
    chk_snap("R10 switch on without tick");
    repeat (50) @(negedge clk);
    chk_snap("R10 held without tick");
    tick = 1'b1;
    begin
      int n = 0;
      while (busy && n < 2000) begin @(negedge clk); n++; end
    end
    m_busy = 1'b0; m_iso = 1'b0; m_clk = 2'b11; m_pow = 1'b1; m_bank = '0; m_aux = '0;
    chk_snap("R10 completes after ticks resume");

    // R1 with switch on at reset, then R8 redundant on
    do_reset(1'b1);
    on_req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      on_req = 1'b0;
      chk_snap("R8 redundant on");
    end
    off_req = 1'b1;
    @(negedge clk); off_req = 1'b0;
    m_busy = 1'b1;
    chk_snap("R11 busy after accepted off");
    @(negedge clk);
    m_iso = 1'b1;
    chk_snap("R2 iso first");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule